// File: doc/BRIEF.md
# Buffered Factory Program Sequencer

This block is the device-side engine of a high-throughput factory programming mode for a parallel flash command interface. An upstream command decoder sends a one-cycle start pulse with the starting array address. From then on, each host write cycle (address plus a 16-bit word) is steered into an internal write buffer. The buffer is filled in slot order from slot 0, and the slot a word lands in does not depend on the address it carries.

When the last slot has been written, the block copies the whole buffer to the array through a request/done handshake, one word per request. While that copy runs it raises the busy status bit. Each new buffer continues at the array address just past the end of the previous one. A host write whose address falls in a different block ends the mode at once. The host is expected to supply 0xFFFF with that write, but the word is not examined. If the mode ends mid-fill, the partly filled buffer is dropped. If the start address is not a multiple of the buffer size, the mode never starts and a sticky failure bit is raised.

Top module: `bufprog_seq`

## Requirements
- R1: A start pulse whose address has any of its low log2(BUF_WORDS) bits (bits 8:0 by default) non-zero sets `sr_fail` on the next cycle, leaves `active` low and causes no program request.
- R2: A start pulse with an aligned address, given while the mode is inactive, raises `active` on the next cycle. The first programmed word goes to the start address.
- R3: In-block host writes fill buffer slots 0, 1, 2 … in arrival order. On the clock edge that accepts the BUF_WORDS-th word, `sr_busy` goes high and the transfer starts without any further command.
- R4: The array port carries one word per request. `pgm_req` stays high, with `pgm_addr` and `pgm_data` held, until `pgm_done` is sampled high. Words go out in slot order to consecutive array addresses.
- R5: `sr_busy` goes low on the edge that samples the `pgm_done` of the last word. The block then accepts the next fill, with `active` still high.
- R6: Each further buffer starts at the array address one past the last word of the previous buffer.
- R7: Host writes that arrive while `sr_busy` is high are ignored, including writes outside the current block. They change neither the buffer contents nor the mode.
- R8: A host write outside the current block during a fill ends the mode on the next cycle (`active` low). The words already loaded in that fill are never programmed. The current block is the start address with its low BLK_AW bits (bits 15:0 by default) dropped.
- R9: A write of 0xFFFF to another block at a buffer boundary, with no words loaded, ends the mode without issuing any request.
- R10: `sr_fail` stays high until `clr_status` is pulsed. The pulse clears it on the next cycle.
- R11: After the mode ends, a new aligned start loads its first word into slot 0, so that word is the first one programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to enter the mode |
| start_addr | input | ADDR_W | Start address for the array writes |
| wr_en | input | 1 | Host write cycle strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| clr_status | input | 1 | Clears the failure bit |
| pgm_req | output | 1 | Array program request |
| pgm_addr | output | ADDR_W | Array address of the word being programmed |
| pgm_data | output | DATA_W | Word being programmed |
| pgm_done | input | 1 | Array has finished the current word |
| sr_busy | output | 1 | Status: buffer transfer in progress |
| sr_fail | output | 1 | Status: sticky program failure |
| active | output | 1 | Mode is running |

## Verification
The bench targets the following corner cases.
- **Buffer boundary.** A design with an off-by-one fill counter would start the copy one word early or late. That shows up as busy rising in the wrong cycle and the slot order breaking.
- **Address carry-on.** A second buffer must follow the first. A design that reloaded the start address would program the second buffer over the first.
- **Writes during the copy.** Writes are injected while busy is high, including out-of-block ones. A design that let them through would drop out of the mode or corrupt the next buffer.
- **Aborts.** A fill is aborted part way. A design that kept its fill counter would put the next session's first word in the wrong slot, and one that flushed the partial buffer would issue requests that nobody expects.
- **Failure bit.** Misaligned starts must raise the failure bit and keep it set across a full later session. A design that cleared it anywhere but on the explicit clear would be caught there.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;
  // mode of the fill side
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FILL = 2'd1,
    MODE_XFER = 2'd2
  } mode_t;

  // steps of the array streaming side
  typedef enum logic [1:0] {
    STR_IDLE = 2'd0,
    STR_RD   = 2'd1,
    STR_LD   = 2'd2,
    STR_WAIT = 2'd3
  } strm_t;
endpackage

// File: rtl/bufprog_ram.sv
module bufprog_ram #(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps to one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bufprog_fill.sv
module bufprog_fill
  import bufprog_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int ADDR_W = 24,
  parameter int BLK_AW = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_status,
  input  logic              xfer_done,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              xfer_start,
  output logic              base_load,
  output logic              active,
  output logic              sr_fail
);
  localparam int BLK_W = ADDR_W - BLK_AW;
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  mode_t            mode;
  logic [AW-1:0]    fill_cnt;
  logic [BLK_W-1:0] cur_blk;
  logic             misaligned;
  logic             in_blk;
  logic             accept;
  logic             leave;

  assign misaligned = |start_addr[AW-1:0];
  assign in_blk     = (wr_addr[ADDR_W-1:BLK_AW] == cur_blk);
  assign accept     = (mode == MODE_FILL) && wr_en && in_blk;
  assign leave      = (mode == MODE_FILL) && wr_en && !in_blk;
  assign base_load  = (mode == MODE_IDLE) && start && !misaligned;
  assign xfer_start = accept && (fill_cnt == LAST_SLOT);
  assign ram_we     = accept;
  assign ram_waddr  = fill_cnt;
  assign ram_wdata  = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_IDLE;
      fill_cnt <= '0;
      cur_blk  <= '0;
      active   <= 1'b0;
      sr_fail  <= 1'b0;
    end else begin
      if (clr_status) sr_fail <= 1'b0;
      unique case (mode)
        MODE_IDLE: begin
          if (start && misaligned) sr_fail <= 1'b1;
          if (base_load) begin
            mode     <= MODE_FILL;
            fill_cnt <= '0;
            cur_blk  <= start_addr[ADDR_W-1:BLK_AW];
            active   <= 1'b1;
          end
        end
        MODE_FILL: begin
          if (leave) begin
            mode     <= MODE_IDLE;
            fill_cnt <= '0;
            active   <= 1'b0;
          end else if (accept) begin
            fill_cnt <= fill_cnt + AW'(1);
            if (fill_cnt == LAST_SLOT) mode <= MODE_XFER;
          end
        end
        MODE_XFER: begin
          if (xfer_done) begin
            mode     <= MODE_FILL;
            fill_cnt <= '0;
          end
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end

  // R7
  xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_XFER && !xfer_done) |=> (mode == MODE_XFER && active));

  // R8
  leave_chk: assert property (@(posedge clk) disable iff (rst)
    leave |=> !active);

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sr_fail && !clr_status) |=> sr_fail);

  // R1
  fail_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_fail) |-> $past(start && misaligned && mode == MODE_IDLE));
endmodule

// File: rtl/bufprog_stream.sv
module bufprog_stream
  import bufprog_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              xfer_start,
  output logic [AW-1:0]     ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  input  logic              pgm_done,
  output logic              sr_busy,
  output logic              xfer_done
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  strm_t             st;
  logic [AW-1:0]     idx;
  logic [ADDR_W-1:0] arr_ptr;

  assign ram_raddr = idx;
  assign xfer_done = (st == STR_WAIT) && pgm_done && (idx == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= STR_IDLE;
      idx      <= '0;
      arr_ptr  <= '0;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
      sr_busy  <= 1'b0;
    end else begin
      if (base_load) arr_ptr <= base_addr;
      unique case (st)
        STR_IDLE: begin
          if (xfer_start) begin
            st      <= STR_RD;
            idx     <= '0;
            sr_busy <= 1'b1;
          end
        end
        STR_RD: st <= STR_LD;
        STR_LD: begin
          pgm_req  <= 1'b1;
          pgm_addr <= arr_ptr;
          pgm_data <= ram_rdata;
          st       <= STR_WAIT;
        end
        STR_WAIT: begin
          if (pgm_done) begin
            pgm_req <= 1'b0;
            arr_ptr <= arr_ptr + ADDR_W'(1);
            if (idx == LAST_SLOT) begin
              sr_busy <= 1'b0;
              st      <= STR_IDLE;
            end else begin
              idx <= idx + AW'(1);
              st  <= STR_RD;
            end
          end
        end
        default: st <= STR_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pgm_req && !pgm_done) |=> pgm_req);

  // R4
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pgm_req && !pgm_done) |=> ($stable(pgm_addr) && $stable(pgm_data)));

  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pgm_req |-> sr_busy);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pgm_req && pgm_done && !base_load) |=> (arr_ptr == $past(pgm_addr) + ADDR_W'(1)));
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq #(
  parameter int BUF_WORDS = 512,
  parameter int ADDR_W    = 24,
  parameter int BLK_AW    = 16,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_status,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  input  logic              pgm_done,
  output logic              sr_busy,
  output logic              sr_fail,
  output logic              active
);
  localparam int BUF_AW = $clog2(BUF_WORDS);

  logic              ram_we;
  logic [BUF_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [BUF_AW-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic              xfer_start;
  logic              xfer_done;
  logic              base_load;

  bufprog_fill #(
    .DEPTH(BUF_WORDS), .AW(BUF_AW), .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .DATA_W(DATA_W)
  ) u_fill (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clr_status(clr_status),
    .xfer_done(xfer_done), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .xfer_start(xfer_start), .base_load(base_load), .active(active), .sr_fail(sr_fail)
  );

  bufprog_ram #(
    .DEPTH(BUF_WORDS), .AW(BUF_AW), .DATA_W(DATA_W)
  ) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  bufprog_stream #(
    .DEPTH(BUF_WORDS), .AW(BUF_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_stream (
    .clk(clk), .rst(rst), .base_load(base_load), .base_addr(start_addr),
    .xfer_start(xfer_start), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data), .pgm_done(pgm_done),
    .sr_busy(sr_busy), .xfer_done(xfer_done)
  );
endmodule

// File: tb/bufprog_seq_tb.sv
module bufprog_seq_tb;
  localparam int BUF_WORDS = 512;
  localparam int ADDR_W    = 24;
  localparam int BLK_AW    = 16;
  localparam int DATA_W    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              clr_status = 1'b0;
  logic              pgm_req;
  logic [ADDR_W-1:0] pgm_addr;
  logic [DATA_W-1:0] pgm_data;
  logic              pgm_done = 1'b0;
  logic              sr_busy, sr_fail, active;

  always #4 clk = ~clk;

  bufprog_seq #(.BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clr_status(clr_status),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data), .pgm_done(pgm_done),
    .sr_busy(sr_busy), .sr_fail(sr_fail), .active(active)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_mode = 0;      // 0 idle, 1 fill, 2 transfer
  bit  m_busy = 0, m_fail = 0, m_active = 0;
  longint m_ptr = 0;
  longint m_blk = 0;
  int  buf_q[$];
  longint exp_a[$];
  int  exp_d[$];
  int  hs_data[$];
  int  hs_count = 0;
  longint last_addr = 0;
  bit  model_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_busy = 0; m_fail = 0; m_active = 0;
      buf_q.delete(); exp_a.delete(); exp_d.delete();
    end else begin
      model_on = 1;
      if (clr_status) m_fail = 0;
      if (m_mode == 2 && pgm_req && pgm_done) begin
        if (exp_a.size() == 0) begin
          check(0, "R4 unexpected request", longint'(pgm_addr), 0);
        end else begin
          check(longint'(pgm_addr) == exp_a[0], "R4 R6 program address", longint'(pgm_addr), exp_a[0]);
          check(int'(pgm_data) == exp_d[0], "R3 R4 program data", longint'(pgm_data), longint'(exp_d[0]));
          void'(exp_a.pop_front());
          void'(exp_d.pop_front());
        end
        hs_data.push_back(int'(pgm_data));
        hs_count++;
        last_addr = longint'(pgm_addr);
        if (exp_a.size() == 0) begin m_busy = 0; m_mode = 1; end
      end else if (m_mode == 0 && start) begin
        if ((start_addr % BUF_WORDS) != 0) m_fail = 1;
        else begin
          m_mode = 1; m_active = 1; m_ptr = longint'(start_addr);
          m_blk = longint'(start_addr) >> BLK_AW;
          buf_q.delete(); hs_data.delete();
        end
      end else if (m_mode == 1 && wr_en) begin
        if ((longint'(wr_addr) >> BLK_AW) != m_blk) begin
          m_mode = 0; m_active = 0; buf_q.delete();
        end else begin
          buf_q.push_back(int'(wr_data));
          if (buf_q.size() == BUF_WORDS) begin
            foreach (buf_q[i]) begin
              exp_a.push_back(m_ptr + i);
              exp_d.push_back(buf_q[i]);
            end
            m_ptr += BUF_WORDS;
            buf_q.delete();
            m_mode = 2; m_busy = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(sr_busy == m_busy, "R3 R5 busy", longint'(sr_busy), longint'(m_busy));
      check(sr_fail == m_fail, "R1 R10 fail", longint'(sr_fail), longint'(m_fail));
      check(active == m_active, "R2 R7 R8 active", longint'(active), longint'(m_active));
      if (pgm_req && !m_busy) check(0, "R4 request outside transfer", 1, 0);
    end
  end

  // array responder
  initial begin
    forever begin
      @(negedge clk);
      if (pgm_req && !pgm_done) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        pgm_done = 1'b1;
        @(negedge clk);
        pgm_done = 1'b0;
      end
    end
  end

  task automatic do_start(input logic [ADDR_W-1:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (sr_busy);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  localparam logic [ADDR_W-1:0] BASE  = 24'h010200;
  localparam logic [ADDR_W-1:0] OTHER = 24'h020000;
  localparam logic [ADDR_W-1:0] BASE2 = 24'h030400;

  initial begin
    int hs0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sr_busy && !sr_fail && !active && !pgm_req, "reset state", {sr_busy, sr_fail, active, pgm_req}, 0);

    // R1 misaligned start
    do_start(24'h010203);
    check(sr_fail == 1'b1, "R1 fail set", sr_fail, 1);
    check(active == 1'b0, "R1 mode not entered", active, 0);
    // R10 clear
    do_clear();
    check(sr_fail == 1'b0, "R10 clear", sr_fail, 0);

    // R2 aligned start, R3 fill
    do_start(BASE);
    check(active == 1'b1, "R2 active", active, 1);
    hs0 = hs_count;
    for (int i = 0; i < BUF_WORDS; i++) do_write(BASE + ADDR_W'(i), DATA_W'(16'h1000 + i * 3));
    check(sr_busy == 1'b1, "R3 busy after last word", sr_busy, 1);
    // R7 writes during transfer are ignored
    do_write(OTHER, 16'hFFFF);
    do_write(BASE + 24'd5, 16'hDEAD);
    do_write(OTHER + 24'd7, 16'hBEEF);
    check(active == 1'b1 && sr_busy == 1'b1, "R7 still in transfer", {active, sr_busy}, 3);
    wait_idle();
    check(active == 1'b1, "R5 back to fill", active, 1);
    check(hs_count - hs0 == BUF_WORDS, "R4 word count", hs_count - hs0, BUF_WORDS);
    check(last_addr == longint'(BASE) + BUF_WORDS - 1, "R2 R4 last address", last_addr, longint'(BASE) + BUF_WORDS - 1);

    // R6 second buffer continues
    for (int i = 0; i < BUF_WORDS; i++) do_write(BASE + ADDR_W'(i), ~DATA_W'(i));
    wait_idle();
    check(last_addr == longint'(BASE) + 2 * BUF_WORDS - 1, "R6 carry-on address", last_addr, longint'(BASE) + 2 * BUF_WORDS - 1);

    // R8 partial fill then out-of-block write
    hs0 = hs_count;
    for (int i = 0; i < 100; i++) do_write(BASE + ADDR_W'(i), DATA_W'(16'h5000 + i));
    do_write(OTHER, 16'h1234);
    check(active == 1'b0, "R8 mode ended", active, 0);
    repeat (20) @(negedge clk);
    check(hs_count == hs0 && !pgm_req, "R8 nothing programmed", hs_count - hs0, 0);

    // R10 sticky across a session, R11 restart at slot 0
    do_start(24'h030001);
    check(sr_fail == 1'b1, "R1 second misaligned", sr_fail, 1);
    do_start(BASE2);
    check(active == 1'b1, "R2 restart", active, 1);
    for (int i = 0; i < BUF_WORDS; i++)
      do_write(BASE2 + ADDR_W'(i), (i < 10) ? DATA_W'(16'h7700 + i) : 16'hFFFF);
    wait_idle();
    check(hs_data.size() > 0 && hs_data[0] == 16'h7700, "R11 first word from slot 0",
          (hs_data.size() > 0) ? hs_data[0] : -1, 16'h7700);
    check(sr_fail == 1'b1, "R10 fail held", sr_fail, 1);

    // R9 exit at buffer boundary
    hs0 = hs_count;
    do_write(OTHER, 16'hFFFF);
    check(active == 1'b0, "R9 exit", active, 0);
    repeat (10) @(negedge clk);
    check(hs_count == hs0, "R9 no request on exit", hs_count - hs0, 0);
    do_clear();
    check(sr_fail == 1'b0, "R10 cleared", sr_fail, 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule